// File: doc/BRIEF.md
# Condition Flags and Branch Decision Unit

This block keeps the four condition flags of a processor core (negative, zero, carry, overflow) and decides, each cycle, whether the branch being evaluated is taken. The flags are loaded from the ALU result, carry-out and overflow, but only when the executing operation is a flag-setting variant. Every other operation leaves them untouched.

The taken decision is combinational from the stored flags, the branch kind, the 4-bit condition code and a register value. The register value serves the branch forms that test a register for zero or non-zero. Both the signed and the unsigned forms of each ordered comparison are supported. They assume the flags were produced by a subtraction A minus B, where carry set means no borrow. The block does not compute the branch target and does not contain the ALU.

Top module: `cond_branch_unit`

## Requirements
- R1: When `set_flags` is 1 at a rising clock edge, `flags_q` takes the following values after that edge: bit 3 (N) is the result's most significant bit, bit 2 (Z) is 1 exactly when the result is all zeros, bit 1 (C) is `alu_carry`, and bit 0 (V) is `alu_ovf`.
- R2: When `set_flags` is 0 at a rising clock edge, `flags_q` keeps its value, whatever the branch kind, register value or ALU inputs are.
- R3: While `rst_n` is low, `flags_q` is 0.
- R4: With `br_kind` = 4 (conditional), the signed and equality codes decide `take` as follows: 0 equal (Z), 1 not equal (!Z), 10 greater-or-equal (N==V), 11 less-than (N!=V), 12 greater-than (!Z and N==V), 13 less-or-equal (Z or N!=V).
- R5: With `br_kind` = 4, the unsigned codes decide `take` as follows: 2 higher-or-same (C), 3 lower (!C), 8 higher (C and !Z), 9 lower-or-same (!C or Z). Codes 4 to 7, 14 and 15 give `take` = 0.
- R6: `br_kind` = 2 takes the branch exactly when `reg_val` is zero, and `br_kind` = 3 takes it exactly when `reg_val` is non-zero. Both forms ignore the flags.
- R7: `br_kind` = 1 always gives `take` = 1. Kinds 0, 5, 6 and 7 always give `take` = 0.
- R8: A branch evaluated in the same cycle as a flag write uses the flags from before that write. The new flags affect `take` only from the next cycle.
- R9: After the flags are set by all-ones minus one, the signed less-than code is taken and greater-than is not. The unsigned lower code is not taken and higher is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_res | input | DATA_W | ALU result |
| alu_carry | input | 1 | Carry out of the ALU's most significant bit |
| alu_ovf | input | 1 | ALU signed overflow |
| set_flags | input | 1 | Load the flags at this edge |
| br_kind | input | 3 | 0 none, 1 always, 2 register zero, 3 register non-zero, 4 conditional |
| cond | input | 4 | Condition code for kind 4 |
| reg_val | input | DATA_W | Register tested by kinds 2 and 3 |
| take | output | 1 | Branch is taken |
| flags_q | output | 4 | Stored flags {N,Z,C,V} |

## Verification
Random subtraction results feed the flags, so N, Z, C and V appear in many combinations. Every condition code is then evaluated against them, and a wrong term in any condition shows up as a mismatch. Zero results and zero register values are forced often, which tells the Z-driven and register-zero paths apart from the ordinary ones. Directed cases cover the all-ones against plus-one operand pair, which separates signed from unsigned ordering. They also cover equal operands, which separates the strict conditions from the non-strict ones. A flag write combined with a branch in the same cycle shows whether the evaluation uses the old or the new flags.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  typedef enum logic [2:0] {
    BK_NONE   = 3'd0,
    BK_ALWAYS = 3'd1,
    BK_RZERO  = 3'd2,
    BK_RNZERO = 3'd3,
    BK_COND   = 3'd4
  } br_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam logic [3:0] CC_EQ = 4'd0;
  localparam logic [3:0] CC_NE = 4'd1;
  localparam logic [3:0] CC_HS = 4'd2;
  localparam logic [3:0] CC_LO = 4'd3;
  localparam logic [3:0] CC_HI = 4'd8;
  localparam logic [3:0] CC_LS = 4'd9;
  localparam logic [3:0] CC_GE = 4'd10;
  localparam logic [3:0] CC_LT = 4'd11;
  localparam logic [3:0] CC_GT = 4'd12;
  localparam logic [3:0] CC_LE = 4'd13;

endpackage

// File: rtl/cbr_flag_gen.sv
module cbr_flag_gen
  import cbr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] res,
  input  logic              carry,
  input  logic              ovf,
  output flags_t            nxt
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    nxt.n = res[MSB];
    nxt.z = ~|res;
    nxt.c = carry;
    nxt.v = ovf;
  end
endmodule

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
  import cbr_pkg::*;
(
  input  flags_t     f,
  input  logic [3:0] code,
  output logic       hit
);
  logic sgn_ge;

  always_comb begin
    sgn_ge = (f.n == f.v);
    unique case (code)
      CC_EQ:   hit = f.z;
      CC_NE:   hit = ~f.z;
      CC_HS:   hit = f.c;
      CC_LO:   hit = ~f.c;
      CC_HI:   hit = f.c & ~f.z;
      CC_LS:   hit = ~f.c | f.z;
      CC_GE:   hit = sgn_ge;
      CC_LT:   hit = ~sgn_ge;
      CC_GT:   hit = ~f.z & sgn_ge;
      CC_LE:   hit = f.z | ~sgn_ge;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbr_take_sel.sv
module cbr_take_sel
  import cbr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [2:0]        kind,
  input  logic              cond_hit,
  input  logic [DATA_W-1:0] rv,
  output logic              take
);
  logic rv_zero;
  br_kind_e k;

  always_comb begin
    rv_zero = ~|rv;
    k       = br_kind_e'(kind);
    case (k)
      BK_ALWAYS: take = 1'b1;
      BK_RZERO:  take = rv_zero;
      BK_RNZERO: take = ~rv_zero;
      BK_COND:   take = cond_hit;
      default:   take = 1'b0;
    endcase
  end
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              set_flags,
  input  logic [2:0]        br_kind,
  input  logic [3:0]        cond,
  input  logic [DATA_W-1:0] reg_val,
  output logic              take,
  output logic [3:0]        flags_q
);
  flags_t flg_q;
  flags_t flg_d;
  flags_t flg_new;
  logic   cond_hit;

  cbr_flag_gen #(.DATA_W(DATA_W)) u_gen (
    .res   (alu_res),
    .carry (alu_carry),
    .ovf   (alu_ovf),
    .nxt   (flg_new)
  );

  // next-state: clock enable written out
  always_comb begin
    flg_d = flg_q;
    if (set_flags) flg_d = flg_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  // evaluation uses registered flags only
  cbr_cond_eval u_eval (
    .f    (flg_q),
    .code (cond),
    .hit  (cond_hit)
  );

  cbr_take_sel #(.DATA_W(DATA_W)) u_sel (
    .kind     (br_kind),
    .cond_hit (cond_hit),
    .rv       (reg_val),
    .take     (take)
  );

  assign flags_q = flg_q;
endmodule

// File: rtl/cond_branch_unit_chk.sv
module cond_branch_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] alu_res,
  input logic              alu_carry,
  input logic              alu_ovf,
  input logic              set_flags,
  input logic [2:0]        br_kind,
  input logic [3:0]        cond,
  input logic [DATA_W-1:0] reg_val,
  input logic              take,
  input logic [3:0]        flags_q
);
  // R1
  a_r1_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> flags_q[2] == ($past(alu_res) == '0));
  a_r1_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> flags_q[3] == $past(alu_res[DATA_W-1]));
  a_r1_cv_flags: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> flags_q[1:0] == {$past(alu_carry), $past(alu_ovf)});
  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable(flags_q));
  // R7
  a_r7_always: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 3'd1) |-> take);
  a_r7_none: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 3'd0 || br_kind > 3'd4) |-> !take);
  // R6
  a_r6_reg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 3'd2) |-> take == (reg_val == '0));
  a_r6_reg_nzero: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 3'd3) |-> take == (reg_val != '0));
  // R4
  a_r4_eq: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 3'd4 && cond == 4'd0) |-> take == flags_q[2]);
endmodule

bind cond_branch_unit cond_branch_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cond_branch_unit_bench.sv
module cond_branch_unit_bench;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] alu_res;
  logic         alu_carry, alu_ovf, set_flags;
  logic [2:0]   br_kind;
  logic [3:0]   cond;
  logic [W-1:0] reg_val;
  logic         take;
  logic [3:0]   flags_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [3:0] mdl;  // bench model of flags {N,Z,C,V}

  always #5 clk = ~clk;

  cond_branch_unit #(.DATA_W(W)) u_cond_branch_unit (.*);

  function automatic logic f_cond(input logic [3:0] f, input logic [3:0] c);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic f_take(input logic [3:0] f, input logic [2:0] k,
                                  input logic [3:0] c, input logic [W-1:0] rv);
    case (k)
      3'd1: return 1'b1;
      3'd2: return rv == '0;
      3'd3: return rv != '0;
      3'd4: return f_cond(f, c);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive ALU outputs as for a subtraction a - b
  task automatic drive_sub(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, ~b} + 1;
    alu_res   = s[W-1:0];
    alu_carry = s[W];
    alu_ovf   = (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
  endtask

  // one cycle: inputs already driven after a negedge
  task automatic cycle(input string req);
    logic [3:0] nf;
    #1;
    chk({req, " take"}, {3'b0, take}, {3'b0, f_take(mdl, br_kind, cond, reg_val)});
    nf = {alu_res[W-1], alu_res == '0, alu_carry, alu_ovf};
    @(posedge clk);
    #1;
    if (set_flags) mdl = nf;
    chk({req, " flags"}, flags_q, mdl);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    rst_n = 0; alu_res = '0; alu_carry = 0; alu_ovf = 0; set_flags = 0;
    br_kind = 0; cond = 0; reg_val = '0; mdl = 4'h0;
    repeat (3) @(negedge clk);
    #1;
    chk("R3 reset flags", flags_q, 4'h0);
    chk("R7 reset none", {3'b0, take}, 4'h0);
    rst_n = 1;
    @(negedge clk);

    // R9: all-ones minus one
    drive_sub('1, 64'd1); set_flags = 1; br_kind = 3'd0;
    cycle("R1 set");
    set_flags = 0; br_kind = 3'd4;
    cond = 4'd11; cycle("R9 LT");
    chk("R9 LT taken", {3'b0, take}, 4'h1);
    cond = 4'd12; cycle("R9 GT");
    cond = 4'd3;  cycle("R9 LO");
    cond = 4'd8;  cycle("R9 HI");

    // equal operands: strict vs non-strict, R4/R5
    drive_sub(64'd77, 64'd77); set_flags = 1; br_kind = 3'd0;
    cycle("R1 equal");
    set_flags = 0; br_kind = 3'd4;
    for (int c = 0; c < 16; c++) begin
      cond = c[3:0];
      cycle((c inside {2, 3, 8, 9}) ? "R5 equal" : "R4 equal");
    end

    // R8: same-cycle write, evaluation sees old flags (Z=1 now)
    drive_sub(64'd5, 64'd2); set_flags = 1; br_kind = 3'd4; cond = 4'd0;
    #1;
    chk("R8 old flags", {3'b0, take}, 4'h1);
    cycle("R8 write");
    set_flags = 0;
    #1;
    chk("R8 new flags", {3'b0, take}, 4'h0);
    cycle("R8 after");

    // R6/R2: register forms with flags held
    br_kind = 3'd2; reg_val = '0; alu_res = '0; cycle("R6 zero");
    reg_val = 64'h100; cycle("R6 zero nz");
    br_kind = 3'd3; cycle("R6 nzero");
    reg_val = '0; cycle("R6 nzero z R2");

    // random mix: R1 R2 R4 R5 R6 R7
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] a, b;
      a = {$urandom, $urandom};
      b = ($urandom_range(0, 7) == 0) ? a : {$urandom, $urandom};
      if ($urandom_range(0, 5) == 0) b = ~a + 1'b1 - 1'b1 + (a - a);
      drive_sub(a, b);
      set_flags = $urandom_range(0, 1);
      br_kind = $urandom_range(0, 7);
      cond = $urandom_range(0, 15);
      reg_val = ($urandom_range(0, 3) == 0) ? '0 : {$urandom, $urandom};
      cycle("R4 R5 R6 R7 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule